// File: doc/BRIEF.md
# Serial Interrupt Host Frame Sampler

This block is the host end of a single-wire serialized interrupt line. It runs on the bus clock and repeats a fixed frame cycle. It pulls the line low to open each cycle. Then it steps through seventeen data frames and reads one interrupt level from each of the first sixteen. Last, it pulls the line low again for a short stop window. The seventeenth frame is the I/O channel-check slot. The host times that frame so that its counting stays in step, but the slot never becomes an interrupt.

The sampled levels are held in a shadow register while the cycle runs. When the last frame has gone by, the shadow is committed. At that point the sampled vector and the status register update together and a one-clock done strobe fires. For each line, a rising-edge pulse is also raised when its level went from deasserted to asserted since the previous cycle. A downstream message generator uses the status for level-style signalling and the edge pulses for edge-style signalling.

Top module: `sirq_host`

## Requirements
- R1: A cycle is 61 clocks. The host drives the line low for 6 clocks (start), then releases it for 1 turnaround clock. Next come 17 data frames of 3 clocks each, then 2 driven-low stop clocks, then 1 idle clock before the next start.
- R2: `sirq_oe` is high only in the start and stop windows. `sirq_out` is low whenever `sirq_oe` is high.
- R3: Data frame n of a cycle is read only in its first clock (the sample clock). The line is active-low, so bit n becomes 1 when `sirq_in` is 0 in that clock. The second and third clocks of a frame (recovery and turnaround) have no effect.
- R4: The seventeenth data frame (index 16) never changes `irq_vec`, `irq_status` or `irq_edge`, whatever the line does during it.
- R5: `cycle_done` is high for exactly one clock per cycle. That clock is the first stop clock, which is the clock after the last data frame.
- R6: `irq_vec` and `irq_status` both take the sixteen levels sampled in the cycle, in the same clock that `cycle_done` is high. Between commits they hold their value.
- R7: `irq_edge` is high only together with `cycle_done`. Bit n is then high if bit n of the new levels is 1 and bit n of the previous status was 0.
- R8: A synchronous active-high `rst` clears `irq_vec`, `irq_status`, `irq_edge` and `cycle_done`, and restarts the sequence at the first start clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sirq_in | input | 1 | Level seen on the shared interrupt line |
| sirq_out | output | 1 | Value driven by the host when enabled (low in its windows) |
| sirq_oe | output | 1 | Host drive enable for the open-drain line |
| irq_vec | output | 16 | Levels sampled in the last completed cycle, 1 = asserted |
| irq_status | output | 16 | Per-line status register for level signalling |
| irq_edge | output | 16 | One-clock rising-edge flags, raised with `cycle_done` |
| cycle_done | output | 1 | One-clock strobe when a cycle's levels are committed |

## Verification
A slip in the frame counter or the slot counter shows at the ports within one cycle. It appears either as a stop window that is out of place on `sirq_oe` or as levels that are shifted by one line in the next commit. The bench drives the recovery and turnaround clocks to the opposite of each sample level, so reading the wrong slot inverts bits on the very next `cycle_done`. It asserts the channel-check slot in every other cycle to catch a sample that was taken from frame 16. A corrupt status register shows in the edge flags of the cycle after it.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int DEF_IRQ_W      = 16;
    localparam int DEF_FRAMES     = 17;
    localparam int DEF_START_CLKS = 6;
    localparam int DEF_STOP_CLKS  = 2;

    typedef enum logic [2:0] {
        PH_START,
        PH_TURN,
        PH_DATA,
        PH_STOP,
        PH_IDLE
    } phase_e;

    typedef enum logic [1:0] {
        SL_SAMPLE,
        SL_RECOVER,
        SL_TURN
    } slot_e;

    function automatic slot_e next_slot(slot_e s);
        case (s)
            SL_SAMPLE:  return SL_RECOVER;
            SL_RECOVER: return SL_TURN;
            default:    return SL_SAMPLE;
        endcase
    endfunction

    function automatic logic host_drives(phase_e p);
        return (p == PH_START) || (p == PH_STOP);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int FRAMES     = DEF_FRAMES,
    parameter int START_CLKS = DEF_START_CLKS,
    parameter int STOP_CLKS  = DEF_STOP_CLKS,
    localparam int FW        = $clog2(FRAMES),
    localparam int CW        = $clog2(max2(START_CLKS, STOP_CLKS) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [FW-1:0] frame_idx,
    output logic          sample_stb,
    output logic          commit,
    output logic          drive_oe
);

    phase_e        phase_q;
    slot_e         slot_q;
    logic [CW-1:0] cnt_q;
    logic [FW-1:0] frame_q;

    logic start_last;
    logic stop_last;
    logic frame_last;

    assign start_last = (cnt_q == CW'(START_CLKS - 1));
    assign stop_last  = (cnt_q == CW'(STOP_CLKS - 1));
    assign frame_last = (frame_q == FW'(FRAMES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_START;
            slot_q  <= SL_SAMPLE;
            cnt_q   <= '0;
            frame_q <= '0;
        end else begin
            case (phase_q)
                PH_START: begin
                    if (start_last) begin
                        phase_q <= PH_TURN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_TURN: begin
                    phase_q <= PH_DATA;
                    slot_q  <= SL_SAMPLE;
                    frame_q <= '0;
                end
                PH_DATA: begin
                    slot_q <= next_slot(slot_q);
                    if (slot_q == SL_TURN) begin
                        if (frame_last) begin
                            phase_q <= PH_STOP;
                            cnt_q   <= '0;
                        end else begin
                            frame_q <= frame_q + 1'b1;
                        end
                    end
                end
                PH_STOP: begin
                    if (stop_last) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_START;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign frame_idx  = frame_q;
    assign sample_stb = (phase_q == PH_DATA) && (slot_q == SL_SAMPLE);
    assign commit     = (phase_q == PH_DATA) && (slot_q == SL_TURN) && frame_last;
    assign drive_oe   = host_drives(phase_q);

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture
    import sirq_pkg::*;
#(
    parameter int IRQ_W  = DEF_IRQ_W,
    parameter int FRAMES = DEF_FRAMES,
    localparam int FW    = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic             sample_stb,
    input  logic [FW-1:0]    frame_idx,
    input  logic             commit,
    output logic [IRQ_W-1:0] shadow,
    output logic [IRQ_W-1:0] vec
);

    logic [IRQ_W-1:0] shadow_q;
    logic [IRQ_W-1:0] vec_q;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[i] <= 1'b0;
            end else if (sample_stb && (frame_idx == FW'(i))) begin
                shadow_q[i] <= ~line_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (commit) begin
            vec_q <= shadow_q;
        end
    end

    assign shadow = shadow_q;
    assign vec    = vec_q;

endmodule

// File: rtl/sirq_track.sv
module sirq_track
    import sirq_pkg::*;
#(
    parameter int IRQ_W = DEF_IRQ_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [IRQ_W-1:0] levels,
    output logic [IRQ_W-1:0] status,
    output logic [IRQ_W-1:0] edge_pulse,
    output logic             done
);

    logic [IRQ_W-1:0] status_q;
    logic [IRQ_W-1:0] edge_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            edge_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= commit;
            if (commit) begin
                status_q <= levels;
                edge_q   <= levels & ~status_q;
            end else begin
                edge_q <= '0;
            end
        end
    end

    assign status     = status_q;
    assign edge_pulse = edge_q;
    assign done       = done_q;

endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_pkg::*;
#(
    parameter int IRQ_W      = DEF_IRQ_W,
    parameter int FRAMES     = DEF_FRAMES,
    parameter int START_CLKS = DEF_START_CLKS,
    parameter int STOP_CLKS  = DEF_STOP_CLKS,
    localparam int FW        = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sirq_in,
    output logic             sirq_out,
    output logic             sirq_oe,
    output logic [IRQ_W-1:0] irq_vec,
    output logic [IRQ_W-1:0] irq_status,
    output logic [IRQ_W-1:0] irq_edge,
    output logic             cycle_done
);

    logic [FW-1:0]    frame_idx;
    logic             sample_stb;
    logic             commit;
    logic             drive_oe;
    logic [IRQ_W-1:0] shadow;

    sirq_seq #(
        .FRAMES    (FRAMES),
        .START_CLKS(START_CLKS),
        .STOP_CLKS (STOP_CLKS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .frame_idx (frame_idx),
        .sample_stb(sample_stb),
        .commit    (commit),
        .drive_oe  (drive_oe)
    );

    sirq_capture #(
        .IRQ_W (IRQ_W),
        .FRAMES(FRAMES)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .line_in   (sirq_in),
        .sample_stb(sample_stb),
        .frame_idx (frame_idx),
        .commit    (commit),
        .shadow    (shadow),
        .vec       (irq_vec)
    );

    sirq_track #(
        .IRQ_W(IRQ_W)
    ) u_trk (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .levels    (shadow),
        .status    (irq_status),
        .edge_pulse(irq_edge),
        .done      (cycle_done)
    );

    assign sirq_oe  = drive_oe;
    assign sirq_out = ~drive_oe;

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
    parameter int IRQ_W      = 16,
    parameter int START_CLKS = 6,
    parameter int STOP_CLKS  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             sirq_out,
    input logic             sirq_oe,
    input logic [IRQ_W-1:0] irq_vec,
    input logic [IRQ_W-1:0] irq_status,
    input logic [IRQ_W-1:0] irq_edge,
    input logic             cycle_done
);

    logic [7:0] oe_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_run <= '0;
        end else if (sirq_oe) begin
            oe_run <= oe_run + 8'd1;
        end else begin
            oe_run <= '0;
        end
    end

    // R1: a drive window lasts either the start length or the stop length
    assert_drive_window_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(sirq_oe) |-> ((int'(oe_run) == START_CLKS) || (int'(oe_run) == STOP_CLKS)));

    assert_drive_low_R2: assert property (@(posedge clk) disable iff (rst)
        sirq_oe |-> !sirq_out);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        cycle_done |=> !cycle_done);

    assert_done_in_stop_R5: assert property (@(posedge clk) disable iff (rst)
        cycle_done |-> sirq_oe);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !cycle_done |-> ($stable(irq_vec) && $stable(irq_status)));

    assert_same_R6: assert property (@(posedge clk) disable iff (rst)
        irq_vec == irq_status);

    assert_edge_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !cycle_done |-> (irq_edge == '0));

    assert_edge_value_R7: assert property (@(posedge clk) disable iff (rst)
        cycle_done |-> (irq_edge == (irq_status & ~$past(irq_status))));

endmodule

bind sirq_host sirq_host_chk #(
    .IRQ_W     (IRQ_W),
    .START_CLKS(START_CLKS),
    .STOP_CLKS (STOP_CLKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sirq_out  (sirq_out),
    .sirq_oe   (sirq_oe),
    .irq_vec   (irq_vec),
    .irq_status(irq_status),
    .irq_edge  (irq_edge),
    .cycle_done(cycle_done)
);

// File: tb/test_sirq_host.sv
module test_sirq_host;

    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 61;
    localparam int NCYC       = 30;
    localparam int DATA0      = 7;
    localparam int DONE_P     = 58;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        periph = 1'b1;
    logic        sirq_in;
    logic        sirq_out;
    logic        sirq_oe;
    logic [15:0] irq_vec;
    logic [15:0] irq_status;
    logic [15:0] irq_edge;
    logic        cycle_done;

    int checks   = 0;
    int failures = 0;
    int t        = 0;
    bit running  = 1'b0;
    bit ended    = 1'b0;
    logic [15:0] exp_vec = '0;

    assign sirq_in = periph & (sirq_oe ? sirq_out : 1'b1);

    sirq_host i_sirq_host (
        .clk       (clk),
        .rst       (rst),
        .sirq_in   (sirq_in),
        .sirq_out  (sirq_out),
        .sirq_oe   (sirq_oe),
        .irq_vec   (irq_vec),
        .irq_status(irq_status),
        .irq_edge  (irq_edge),
        .cycle_done(cycle_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) t <= 0;
        else     t <= t + 1;
    end

    function automatic logic [15:0] pat(int c);
        if (c < 0)  return 16'h0000;
        if (c < 16) return 16'(1 << c);
        case (c)
            16: return 16'h0000;
            17: return 16'hFFFF;
            18: return 16'hFFFF;
            19: return 16'hA5A5;
            20: return 16'h5A5A;
            21: return 16'h0000;
            default: return 16'((c * 40503) ^ (c << 7));
        endcase
    endfunction

    // Peripheral side: sample clock carries the active-low level, other slots the opposite (R3)
    function automatic logic drive_for(int c, int p);
        int f;
        int s;
        logic asserted;
        if (p < DATA0 || p >= DATA0 + 17 * 3) return 1'b1;
        f = (p - DATA0) / 3;
        s = (p - DATA0) % 3;
        if (f < 16) asserted = pat(c)[f];
        else        asserted = (c % 2 == 1); // R4: channel-check slot asserted on odd cycles
        return (s == 0) ? ~asserted : asserted;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            int c;
            int p;
            bit exp_oe;
            c = t / CYC;
            p = t % CYC;
            periph <= drive_for(c, p);
            exp_oe = (p < 6) || (p == DONE_P) || (p == DONE_P + 1);
            // R1 R2: drive windows at start and stop positions only
            check(sirq_oe == exp_oe, "R1", "oe", 32'(sirq_oe), 32'(exp_oe));
            if (sirq_oe) check(sirq_out == 1'b0, "R2", "out", 32'(sirq_out), 32'h0);
            if (p == DONE_P) begin
                check(cycle_done == 1'b1, "R5", "done", 32'(cycle_done), 32'h1);
                // R3 R4: committed levels match the sample-clock pattern only
                check(irq_vec == pat(c), "R3", "vec", 32'(irq_vec), 32'(pat(c)));
                check(irq_status == pat(c), "R6", "status", 32'(irq_status), 32'(pat(c)));
                check(irq_edge == (pat(c) & ~pat(c - 1)), "R7", "edge",
                      32'(irq_edge), 32'(pat(c) & ~pat(c - 1)));
                exp_vec = pat(c);
            end else begin
                check(cycle_done == 1'b0, "R5", "done idle", 32'(cycle_done), 32'h0);
                check(irq_edge == 16'h0, "R7", "edge idle", 32'(irq_edge), 32'h0);
                check(irq_vec == exp_vec && irq_status == exp_vec, "R6", "hold",
                      32'(irq_vec), 32'(exp_vec));
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(irq_vec == 16'h0, "R8", "vec", 32'(irq_vec), 32'h0);
        check(irq_status == 16'h0, "R8", "status", 32'(irq_status), 32'h0);
        check(irq_edge == 16'h0, "R8", "edge", 32'(irq_edge), 32'h0);
        check(cycle_done == 1'b0, "R8", "done", 32'(cycle_done), 32'h0);
        check(sirq_oe == 1'b1, "R8", "oe", 32'(sirq_oe), 32'h1);
        rst = 1'b0;
        running = 1'b1;
        repeat (NCYC * CYC) @(posedge clk);
        @(negedge clk);
        running = 1'b0;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule